// File: doc/BRIEF.md
# SPI Master with Write-Only Command Register

This block is a single-chip-select SPI master that software steers through one write-only command word. A write to the command address can enable the controller, disable it, reset it, flush its receive queue, or ask for the held chip select to be let go. Each of those actions happens only where the written bit is one. Outgoing characters arrive on a valid/ready stream and incoming characters leave on another valid/ready stream. Behind the receive stream sits a small queue that records an overrun when a character arrives with no free slot.

A disable does not cut a character short. If a character is shifting when the disable arrives, the disable waits until that character ends, and then all pins stop being driven. A soft reset acts at once and leaves the controller in slave mode: pins undriven, queue empty, master flag clear. With chip-select hold turned on, the select line stays low from one character to the next. A one-shot release command raises it once the character in flight, or else the next one, has finished.

Stream rules. The transmit side accepts a byte in a cycle where both `tx_valid` and `tx_ready` are high. `tx_ready` is high only while the controller is enabled, idle and has no disable waiting. There is no transmit buffer, so the source holds its byte until it is accepted. The receive side shows the oldest queued byte while `rx_valid` is high, and holds that byte unchanged until `rx_ready` takes it.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset the controller is disabled, idle and in slave mode: `enabled`, `busy`, `master_mode`, `tx_ready`, `rx_valid`, `overrun` and all three output enables are 0, and `cs_n` is 1.
- R2: A write of zero to a command bit has no effect. Only bits 0 (enable), 1 (disable), 7 (soft reset), 8 (flush) and 24 (release) of the word written at address 0x0 act. A write at any other address, or with only other bits set, changes nothing.
- R3: Writing bit 0 as one, with bit 1 as zero, sets `enabled` and `master_mode` on the next cycle. The SCK, MOSI and chip-select outputs are then driven, and `tx_ready` rises.
- R4: A write with both bit 0 and bit 1 set leaves the controller disabled.
- R5: A disable written while idle clears `enabled` on the next cycle. All output enables and `tx_ready` then go low, and an offered byte does not start a transfer.
- R6: A disable written while `busy` leaves `enabled` high until the character ends. `enabled` falls in the same cycle as `busy`, and the received byte is still queued.
- R7: A character is 8 bits, MSB first, SPI mode 0: MISO is sampled on the rising SCK edge and MOSI changes on the falling edge. The SCK period is 2*SCK_HALF clock cycles.
- R8: Writing bit 7 as one aborts any transfer. On the next cycle the controller is disabled and in slave mode, `busy` is 0, `cs_n` is 1, the queue is empty and `overrun` is 0.
- R9: A received byte that arrives while the queue holds FIFO_DEPTH bytes is dropped and sets `overrun`. The queued bytes are kept, and `overrun` stays set until a flush or a soft reset.
- R10: Writing bit 8 as one empties the queue and clears `overrun` only when `fifo_mode` is 1 and `overrun` is 1. Otherwise it is ignored.
- R11: With `cs_hold` at 0, `cs_n` rises after every character. With `cs_hold` at 1 it stays low between characters.
- R12: Writing bit 24 as one raises a held `cs_n` as the current character ends, or as the next one ends if the controller is idle. The request is used up by that release, so later characters are held again.
- R13: `busy` rises on the cycle after a byte is accepted, and `tx_ready` is 0 while `busy`. While `rx_valid` is 1 and `rx_ready` is 0, `rx_data` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address; the command word is at 0x0 |
| wr_data | input | 32 | Command word |
| fifo_mode | input | 1 | Allows the flush command to act |
| cs_hold | input | 1 | Keeps chip select low between characters |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte can be accepted |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Oldest received byte |
| rx_ready | input | 1 | Consumer takes the received byte |
| sck | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Serial data out enable |
| cs_n | output | 1 | Active-low chip select |
| cs_oe | output | 1 | Chip select output enable |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A character is in flight |
| enabled | output | 1 | Controller enabled |
| master_mode | output | 1 | 1 after an enable, 0 after reset or soft reset |
| overrun | output | 1 | A received byte was dropped because the queue was full |

## Verification
The hardest state to reach is a command that arrives while a character is still shifting: a disable, a chip-select release or a soft reset written partway through a transfer. The bench offers a byte and waits for `busy`. It then issues the register write in the middle of the shift and checks the outputs both before and after the character ends. Overrun is reached in a similar way. The bench holds `rx_ready` low across one more transfer than the queue depth, and then tries the flush with `fifo_mode` off, with it on, and with no overrun pending.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int BIT_EN    = 0;
  localparam int BIT_DIS   = 1;
  localparam int BIT_SRST  = 7;
  localparam int BIT_FLUSH = 8;
  localparam int BIT_LAST  = 24;

  typedef struct packed {
    logic en;
    logic dis;
    logic srst;
    logic flush;
    logic last;
  } cmd_t;
endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CMD_ADDR = '0
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cmd_t              cmd
);
  logic hit;
  assign hit = wr_en && (wr_addr == CMD_ADDR);

  // Each action fires only on a one in its bit position
  always_comb begin
    cmd.en    = hit & wr_data[BIT_EN];
    cmd.dis   = hit & wr_data[BIT_DIS];
    cmd.srst  = hit & wr_data[BIT_SRST];
    cmd.flush = hit & wr_data[BIT_FLUSH];
    cmd.last  = hit & wr_data[BIT_LAST];
  end
endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
  parameter int SCK_HALF = 2,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          start,
  input  logic [DW-1:0] tx_byte,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_byte,
  output logic          sck,
  output logic          mosi
);
  localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int BIT_W = (DW > 1) ? $clog2(DW) : 1;

  logic [DIV_W-1:0] div_q;
  logic [BIT_W-1:0] bit_q;
  logic [DW-1:0]    tx_sh, rx_sh;

  assign mosi    = tx_sh[DW-1];
  assign rx_byte = rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      sck   <= 1'b0;
      div_q <= '0;
      bit_q <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
    end else if (clear) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      sck   <= 1'b0;
      div_q <= '0;
      bit_q <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        sck   <= 1'b0;
        div_q <= '0;
        bit_q <= '0;
        tx_sh <= tx_byte;
      end else if (busy) begin
        if (div_q == DIV_W'(SCK_HALF - 1)) begin
          div_q <= '0;
          if (!sck) begin
            // leading edge: capture MISO
            sck   <= 1'b1;
            rx_sh <= {rx_sh[DW-2:0], miso};
          end else begin
            // trailing edge: advance MOSI or finish
            sck <= 1'b0;
            if (bit_q == BIT_W'(DW - 1)) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              tx_sh <= {tx_sh[DW-2:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_rxfifo.sv
module spi_cmd_rxfifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [DW-1:0] pop_data,
  output logic          overrun
);
  // DEPTH must be a power of two so the pointers wrap by themselves
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop;

  assign full      = (cnt == CW'(DEPTH));
  assign pop_valid = (cnt != '0);
  assign pop_data  = mem[rp];
  assign do_push   = push && !full;
  assign do_pop    = pop_valid && pop_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
    end else if (clear) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      if (push && full) overrun <= 1'b1;
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int SCK_HALF   = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int ADDR_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              fifo_mode,
  input  logic              cs_hold,
  input  logic              tx_valid,
  input  logic [7:0]        tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  input  logic              rx_ready,
  output logic              sck,
  output logic              sck_oe,
  output logic              mosi,
  output logic              mosi_oe,
  output logic              cs_n,
  output logic              cs_oe,
  input  logic              miso,
  output logic              busy,
  output logic              enabled,
  output logic              master_mode,
  output logic              overrun
);
  cmd_t       cmd;
  logic       sh_busy, sh_done;
  logic [7:0] sh_rx;
  logic       pend_q, rel_q, start, flush_go, go_off;

  spi_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(32)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cmd(cmd)
  );

  // a character stays in flight until its result lands (done cycle)
  assign busy     = sh_busy | sh_done;
  assign tx_ready = enabled & ~busy & ~pend_q;
  assign start    = tx_valid & tx_ready;
  assign flush_go = cmd.flush & fifo_mode & overrun;
  // disable takes effect now when idle, or at the end of the character
  assign go_off   = (cmd.dis & ~busy) | (sh_done & (pend_q | cmd.dis));

  spi_cmd_shifter #(.SCK_HALF(SCK_HALF), .DW(8)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(cmd.srst), .start(start),
    .tx_byte(tx_data), .miso(miso), .busy(sh_busy), .done(sh_done),
    .rx_byte(sh_rx), .sck(sck), .mosi(mosi)
  );

  spi_cmd_rxfifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clear(cmd.srst | flush_go),
    .push(sh_done), .push_data(sh_rx), .pop_valid(rx_valid),
    .pop_ready(rx_ready), .pop_data(rx_data), .overrun(overrun)
  );

  // enable state, deferred disable and mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled     <= 1'b0;
      master_mode <= 1'b0;
      pend_q      <= 1'b0;
    end else if (cmd.srst) begin
      enabled     <= 1'b0;
      master_mode <= 1'b0;
      pend_q      <= 1'b0;
    end else if (go_off) begin
      enabled <= 1'b0;
      pend_q  <= 1'b0;
    end else if (cmd.dis) begin
      pend_q <= 1'b1;
    end else if (cmd.en) begin
      enabled     <= 1'b1;
      master_mode <= 1'b1;
    end
  end

  // chip select with hold and one-shot release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n  <= 1'b1;
      rel_q <= 1'b0;
    end else if (cmd.srst) begin
      cs_n  <= 1'b1;
      rel_q <= 1'b0;
    end else begin
      if (sh_done && (!cs_hold || rel_q)) begin
        cs_n  <= 1'b1;
        rel_q <= 1'b0;
      end else if (start) begin
        cs_n <= 1'b0;
      end
      if (go_off) cs_n <= 1'b1;
      if (cmd.last) rel_q <= 1'b1;
    end
  end

  // pins go to input whenever the controller is not enabled
  assign sck_oe  = enabled;
  assign mosi_oe = enabled;
  assign cs_oe   = enabled;
endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic [7:0]        rx_data,
  input logic              rx_ready,
  input logic              cs_n,
  input logic              busy,
  input logic              enabled,
  input logic              overrun
);
  logic cmd_hit, srst_w, flush_w;
  assign cmd_hit = wr_en && (wr_addr == '0);
  assign srst_w  = cmd_hit && wr_data[7];
  assign flush_w = cmd_hit && wr_data[8];

  // R6: enabled holds through a character in flight
  a_r6_enable_kept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && enabled && !srst_w) |=> (enabled || !busy));

  // R5: nothing shifts while disabled
  a_r5_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !busy);

  // R4: enable and disable together leave the controller off
  a_r4_disable_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && wr_data[0] && wr_data[1] && !busy) |=> !enabled);

  // R13: an accepted byte starts a character
  a_r13_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !srst_w) |=> busy);

  // R13: receive data held under back-pressure
  a_r13_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !srst_w && !flush_w) |=> (rx_valid && $stable(rx_data)));

  // R11: chip select is low whenever a character is in flight
  a_r11_cs_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

  // R9: overrun is sticky
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !srst_w && !flush_w) |=> overrun);
endmodule

bind spi_cmd_master spi_cmd_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
  .rx_ready(rx_ready), .cs_n(cs_n), .busy(busy), .enabled(enabled), .overrun(overrun)
);

// File: tb/spi_cmd_master_test.sv
`timescale 1ns/1ps
module spi_cmd_master_test;
  localparam int HALF  = 2;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic fifo_mode = 1'b0, cs_hold = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic sck, sck_oe, mosi, mosi_oe, cs_n, cs_oe;
  logic miso = 1'b0;
  logic busy, enabled, master_mode, overrun;

  int n_chk = 0, n_err = 0;
  logic [7:0] slave_byte = '0, s_sh = '0, s_cap = '0;
  time t_prev = 0, t_last = 0;

  always #10 clk = ~clk;

  spi_cmd_master #(.SCK_HALF(HALF), .FIFO_DEPTH(DEPTH), .ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fifo_mode(fifo_mode), .cs_hold(cs_hold), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .sck(sck), .sck_oe(sck_oe), .mosi(mosi), .mosi_oe(mosi_oe), .cs_n(cs_n),
    .cs_oe(cs_oe), .miso(miso), .busy(busy), .enabled(enabled),
    .master_mode(master_mode), .overrun(overrun)
  );

  // slave model, mode 0
  always @(posedge busy) begin s_sh = slave_byte; miso = s_sh[7]; end
  always @(negedge sck)  begin s_sh = {s_sh[6:0], 1'b0}; miso = s_sh[7]; end
  always @(posedge sck)  begin s_cap = {s_cap[6:0], mosi}; t_prev = t_last; t_last = $time; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] a = 4'h0);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic start_byte(input logic [7:0] tx, input logic [7:0] sl);
    @(negedge clk); slave_byte = sl; tx_valid = 1'b1; tx_data = tx;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic drain();
    @(negedge clk); rx_ready = 1'b1;
    while (rx_valid) @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 enabled/busy/master", {enabled, busy, master_mode}, 3'b000);
    chk("R1 cs_n", cs_n, 1);
    chk("R1 oe", {sck_oe, mosi_oe, cs_oe}, 3'b000);
    chk("R1 ready/valid/overrun", {tx_ready, rx_valid, overrun}, 3'b000);
  endtask

  task automatic t_enable();
    wr(32'hFEFF_FE7C);
    chk("R2 other bits ignored", {enabled, master_mode}, 2'b00);
    wr(32'h1, 4'h4);
    chk("R2 other address ignored", enabled, 0);
    wr(32'h1);
    chk("R3 enable", {enabled, master_mode, tx_ready}, 3'b111);
    chk("R3 pins driven", {sck_oe, mosi_oe, cs_oe}, 3'b111);
    wr(32'h0);
    chk("R2 zero write keeps enabled", enabled, 1);
    wr(32'hFEFF_FE7C);
    chk("R2 other bits keep enabled", enabled, 1);
  endtask

  task automatic t_transfer();
    cs_hold = 1'b0;
    start_byte(8'hA5, 8'h3C);
    chk("R13 busy after accept", busy, 1);
    chk("R13 tx_ready low while busy", tx_ready, 0);
    wait_idle();
    chk("R7 mosi MSB first", s_cap, 8'hA5);
    chk("R7 miso captured", {rx_valid, rx_data}, {1'b1, 8'h3C});
    chk("R7 sck period", 32'(t_last - t_prev), 32'(2 * HALF * 20));
    chk("R11 cs released without hold", cs_n, 1);
    repeat (3) @(negedge clk);
    chk("R13 rx held under back-pressure", {rx_valid, rx_data}, {1'b1, 8'h3C});
    drain();
    chk("R13 rx popped", rx_valid, 0);
  endtask

  task automatic t_hold();
    cs_hold = 1'b1;
    start_byte(8'h11, 8'h22); wait_idle();
    chk("R11 cs held between chars", cs_n, 0);
    start_byte(8'h33, 8'h44);
    wr(32'h0100_0000);
    wait_idle();
    chk("R12 release after current char", cs_n, 1);
    start_byte(8'h55, 8'h66); wait_idle();
    chk("R12 one-shot, held again", cs_n, 0);
    wr(32'h0100_0000);
    chk("R12 idle release waits", cs_n, 0);
    start_byte(8'h77, 8'h88); wait_idle();
    chk("R12 release after next char", cs_n, 1);
    drain();
    cs_hold = 1'b0;
  endtask

  task automatic t_deferred();
    start_byte(8'h5A, 8'hC3);
    wr(32'h2);
    chk("R6 enabled kept while busy", {enabled, busy, tx_ready}, 3'b110);
    wait_idle();
    chk("R6 disabled at end", enabled, 0);
    chk("R6 pins released", {sck_oe, mosi_oe, cs_oe}, 3'b000);
    chk("R6 byte delivered", {rx_valid, rx_data}, {1'b1, 8'hC3});
    drain();
  endtask

  task automatic t_idle_off();
    wr(32'h1); wr(32'h2);
    chk("R5 idle disable", {enabled, tx_ready, cs_oe}, 3'b000);
    start_byte(8'hF0, 8'h0F);
    chk("R5 no transfer while off", busy, 0);
    wr(32'h1); wr(32'h3);
    chk("R4 disable wins", enabled, 0);
  endtask

  task automatic t_overrun();
    wr(32'h1);
    fifo_mode = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin start_byte(8'(i), 8'(8'h10 + i)); wait_idle(); end
    chk("R9 full, no overrun", overrun, 0);
    start_byte(8'h99, 8'h14); wait_idle();
    chk("R9 overrun set", overrun, 1);
    chk("R9 oldest kept", rx_data, 8'h10);
    wr(32'h100);
    chk("R10 flush ignored, mode off", {overrun, rx_valid}, 2'b11);
    fifo_mode = 1'b1;
    wr(32'h100);
    chk("R10 flush empties", {overrun, rx_valid}, 2'b00);
    start_byte(8'h01, 8'h77); wait_idle();
    wr(32'h100);
    chk("R10 flush ignored, no overrun", {rx_valid, rx_data}, {1'b1, 8'h77});
    drain();
  endtask

  task automatic t_soft_reset();
    start_byte(8'h01, 8'h02); wait_idle();
    start_byte(8'hAB, 8'hCD);
    repeat (3) @(negedge clk);
    wr(32'h80);
    chk("R8 aborted and off", {busy, enabled, master_mode}, 3'b000);
    chk("R8 cs high, queue empty", {cs_n, rx_valid, overrun, tx_ready}, 4'b1000);
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_transfer();
    t_hold();
    t_deferred();
    t_idle_off();
    t_overrun();
    t_soft_reset();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule